// File: doc/BRIEF.md
# Per-Line Interrupt Sense Front End

This block turns 32 asynchronous input lines into one registered interrupt request. Each line has a 2-bit sense code and a separate edge/level select bit. Together they decide whether the line reacts to both edges, to a rising edge or high level, to a falling edge or low level, or to nothing. Edge hits are held in a sticky event word that software clears by writing ones. Level hits are not stored and track the pin. A per-line enable word gates which lines reach the combined output.

The register port is a plain write strobe with an address and data, plus an address-driven read that returns data in the same cycle. Addresses are 0 and 1 for the two sense-code words, 2 for the level-select word, 3 for the enable word and 4 for the event word. The event word reads back pending edges ORed with live level requests. In the select, enable and event words, line n sits at bit 31-n.

Top module: `irq_sense_top`

## Requirements
- R1: The sense code of line n sits at bits [(15-(n mod 16))*2 +: 2] of the word at address 0 for lines 0..15 and at address 1 for lines 16..31. In the words at addresses 2, 3 and 4, line n is bit 31-n.
- R2: Code 00 latches an event on both a rising and a falling transition of the line. The level-select bit has no effect on this code.
- R3: Code 01 with select bit 0 latches an event on a rising transition only. With select bit 1 it raises a level request while the line is high.
- R4: Code 10 with select bit 0 latches an event on a falling transition only. With select bit 1 it raises a level request while the line is low.
- R5: Code 11 never produces an event or a level request.
- R6: Writing 1 to a bit of the event word at address 4 clears that pending event. Zero bits leave their events alone. An edge detected in the same cycle wins over the clear.
- R7: A level request is never latched. It drops as soon as the synchronized line leaves its active level, and writing 1 to the event word does not remove it.
- R8: A write that changes a line's sense code or its select bit clears that line's pending event in the same cycle. A write that leaves them unchanged keeps the event.
- R9: Lines pass through two synchronizing flops. An edge applied before clock edge k shows as pending after edge k+2, and the interrupt output follows after edge k+3.
- R10: irq_o is a register that holds the OR, over all lines, of (pending event or level request) AND the line's enable bit.
- R11: After reset all registers read zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 32 | Asynchronous input lines, line n on bit n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, same cycle |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The sweep covers every line with every sense code and both select values, so a misplaced field or a wrong bit reversal shows up on the wrong event bit within four clocks of a transition. A pending bit that fails to clear, or a level request that is wrongly latched, shows in the event word right after the following clear write. A lost clear on a mode change shows in the read of the next cycle. A wrong enable gate or a missing output register shows on irq_o one clock after the event word changes.

// File: rtl/irqsense_pkg.sv
// Shared constants and the sense-code encoding for the interrupt sense front end.
// Assumes each control word carries 2-bit fields for half as many lines as it has bits.
package irqsense_pkg;
    localparam int NUM_LINES = 32;
    localparam int FIELD_W   = 2;
    localparam int ADDR_W    = 3;

    typedef enum logic [1:0] {
        SENSE_ANY  = 2'b00,
        SENSE_HIGH = 2'b01,
        SENSE_LOW  = 2'b10,
        SENSE_OFF  = 2'b11
    } sense_e;
endpackage

// File: rtl/irqsense_sync.sv
// Two-flop synchronizer followed by one history flop per line.
// Assumes pin_i is asynchronous. cur_o is the synchronized value, prev_o is that value one cycle older.
module irqsense_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    // Purpose: bring the lines into the clock domain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign cur_o  = sync_q;
    assign prev_o = hist_q;
endmodule

// File: rtl/irqsense_detect.sv
// Per-line decoder: evaluates the synchronized line against its sense code and select bit.
// Assumes vectors are in line order (line n at index n). The output is purely combinational.
module irqsense_detect
    import irqsense_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         cur_i,
    input  logic [W-1:0]         prev_i,
    input  logic [W*FIELD_W-1:0] mode_i,
    input  logic [W-1:0]         lvl_sel_i,
    output logic [W-1:0]         edge_req_o,
    output logic [W-1:0]         lvl_req_o
);
    for (genvar n = 0; n < W; n++) begin : g_line
        logic   rise;
        logic   fall;
        sense_e code;

        assign rise = cur_i[n] & ~prev_i[n];
        assign fall = ~cur_i[n] & prev_i[n];
        assign code = sense_e'(mode_i[n*FIELD_W +: FIELD_W]);

        // Purpose: map the sense code and select bit to an edge hit or a level request.
        always_comb begin
            edge_req_o[n] = 1'b0;
            lvl_req_o[n]  = 1'b0;
            case (code)
                SENSE_ANY: edge_req_o[n] = rise | fall;
                SENSE_HIGH: begin
                    if (lvl_sel_i[n]) lvl_req_o[n]  = cur_i[n];
                    else              edge_req_o[n] = rise;
                end
                SENSE_LOW: begin
                    if (lvl_sel_i[n]) lvl_req_o[n]  = ~cur_i[n];
                    else              edge_req_o[n] = fall;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irqsense_regs.sv
// Register file: sense-code words, level-select word, enable word and the sticky event word.
// Assumes register bit (W-1-n) belongs to line n. Line-ordered vectors go to the detector and the top.
module irqsense_regs
    import irqsense_pkg::*;
#(
    parameter int W  = NUM_LINES,
    parameter int AW = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [W-1:0]         wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [W-1:0]         rd_data,
    input  logic [W-1:0]         edge_req_i,
    input  logic [W-1:0]         lvl_req_i,
    output logic [W*FIELD_W-1:0] mode_o,
    output logic [W-1:0]         lvl_sel_o,
    output logic [W-1:0]         mask_o,
    output logic [W-1:0]         status_o
);
    localparam int PER_CTRL = W / FIELD_W;
    localparam int NCTRL    = W / PER_CTRL;
    localparam logic [AW-1:0] A_LVL  = AW'(NCTRL);
    localparam logic [AW-1:0] A_MASK = AW'(NCTRL + 1);
    localparam logic [AW-1:0] A_EVT  = AW'(NCTRL + 2);

    logic [W-1:0] ctrl_q [NCTRL];
    logic [W-1:0] lvl_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] pend_next;
    logic [NCTRL-1:0] ctrl_we;
    logic         lvl_we;
    logic         mask_we;
    logic         evt_we;
    logic [W-1:0] chg;
    logic [W-1:0] w1c;
    logic [W-1:0] status_rb;
    logic         past_ok;

    for (genvar k = 0; k < NCTRL; k++) begin : g_we
        assign ctrl_we[k] = wr_en && (wr_addr == AW'(k));
    end
    assign lvl_we  = wr_en && (wr_addr == A_LVL);
    assign mask_we = wr_en && (wr_addr == A_MASK);
    assign evt_we  = wr_en && (wr_addr == A_EVT);

    // Purpose: hold the configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCTRL; k++) ctrl_q[k] <= '0;
            lvl_q  <= '0;
            mask_q <= '0;
        end else begin
            for (int k = 0; k < NCTRL; k++) begin
                if (ctrl_we[k]) ctrl_q[k] <= wr_data;
            end
            if (lvl_we)  lvl_q  <= wr_data;
            if (mask_we) mask_q <= wr_data;
        end
    end

    for (genvar n = 0; n < W; n++) begin : g_map
        localparam int K   = n / PER_CTRL;
        localparam int POS = (PER_CTRL - 1 - (n % PER_CTRL)) * FIELD_W;
        localparam int RB  = W - 1 - n;

        assign mode_o[n*FIELD_W +: FIELD_W] = ctrl_q[K][POS +: FIELD_W];
        assign lvl_sel_o[n] = lvl_q[RB];
        assign mask_o[n]    = mask_q[RB];
        assign chg[n] = (ctrl_we[K] && (wr_data[POS +: FIELD_W] != ctrl_q[K][POS +: FIELD_W]))
                      || (lvl_we && (wr_data[RB] != lvl_q[RB]));
        assign w1c[n]       = evt_we && wr_data[RB];
        assign status_rb[RB] = status_o[n];
    end

    // Purpose: a config change clears, a new edge sets, a write-one clears.
    assign pend_next = ((pend_q & ~w1c) | edge_req_i) & ~chg;

    // Purpose: sticky edge events.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_next;
    end

    assign status_o = pend_q | lvl_req_i;

    // Purpose: same-cycle register readback.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NCTRL; k++) begin
            if (rd_addr == AW'(k)) rd_data = ctrl_q[k];
        end
        if (rd_addr == A_LVL)  rd_data = lvl_q;
        if (rd_addr == A_MASK) rd_data = mask_q;
        if (rd_addr == A_EVT)  rd_data = status_rb;
    end

    // Purpose: mark cycles whose previous cycle was out of reset, for history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_set_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((pend_q & ~$past(pend_q) & ~$past(edge_req_i)) == '0));

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((pend_q & $past(w1c & ~edge_req_i)) == '0));

    p_mode_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((pend_q & $past(chg)) == '0));
endmodule

// File: rtl/irq_sense_top.sv
// Top: synchronizer, sense decoder and register file, plus the registered combined request.
// Assumes 32 lines with 2-bit sense codes packed into two words. Reset is synchronous active-low.
module irq_sense_top
    import irqsense_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_i,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NUM_LINES-1:0] wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [NUM_LINES-1:0] rd_data,
    output logic                 irq_o
);
    localparam int W = NUM_LINES;

    logic [W-1:0]         cur;
    logic [W-1:0]         prev;
    logic [W*FIELD_W-1:0] mode;
    logic [W-1:0]         lvl_sel;
    logic [W-1:0]         edge_req;
    logic [W-1:0]         lvl_req;
    logic [W-1:0]         mask;
    logic [W-1:0]         status;
    logic                 irq_q;
    logic                 past_ok;

    irqsense_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    irqsense_detect #(.W(W)) u_detect (
        .cur_i      (cur),
        .prev_i     (prev),
        .mode_i     (mode),
        .lvl_sel_i  (lvl_sel),
        .edge_req_o (edge_req),
        .lvl_req_o  (lvl_req)
    );

    irqsense_regs #(.W(W), .AW(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .edge_req_i (edge_req),
        .lvl_req_i  (lvl_req),
        .mode_o     (mode),
        .lvl_sel_o  (lvl_sel),
        .mask_o     (mask),
        .status_o   (status)
    );

    // Purpose: register the gated OR of all line requests.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status & mask);
    end

    assign irq_o = irq_q;

    // Purpose: mark cycles whose previous cycle was out of reset, for history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_irq_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (irq_o == $past(|(status & mask))));

    p_lvl_needs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_req & ~lvl_sel) == '0);

    for (genvar n = 0; n < W; n++) begin : g_chk
        p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[n*FIELD_W +: FIELD_W] == 2'b11) |-> !(edge_req[n] || lvl_req[n]));
    end
endmodule

// File: tb/tb_irq_sense_top.sv
`timescale 1ns/1ps
// Sweep bench: every line x every sense code x both select values, with expected words computed arithmetically.
module tb_irq_sense_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    irq_sense_top dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic string tag_of(input int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Compose both sense words with line ln at code m and every other line at code 11.
    task automatic set_mode(input int ln, input int m);
        logic [31:0] c0;
        logic [31:0] c1;
        int pos;
        c0 = '1; c1 = '1;
        pos = (15 - (ln % 16)) * 2;
        if (ln < 16) c0[pos +: 2] = 2'(m);
        else         c1[pos +: 2] = 2'(m);
        wr(3'd0, c0);
        wr(3'd1, c1);
    endtask

    task automatic phase_chk(input string nm, input int ln, input bit hit, input bit en);
        logic [31:0] v;
        logic [31:0] ev;
        ev = hit ? (32'h1 << (31 - ln)) : 32'h0;
        rd(3'd4, v);
        chk({nm, " R1 R6 event word"}, v, ev);
        chk({nm, " R10 irq"}, {31'h0, irq_o}, {31'h0, hit && en});
    endtask

    initial begin
        logic [31:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R11: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R11 reset register", v, 32'h0);
        end
        chk("R11 reset irq", {31'h0, irq_o}, 32'h0);

        // R9: latency from pin to event and to irq (line 7, code 01 edge)
        set_mode(7, 1);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h1 << 24);
        wr(3'd4, 32'hFFFF_FFFF);
        cyc(3);
        pin_i[7] = 1'b1;
        cyc(2);
        rd(3'd4, v);
        chk("R9 event not yet after two edges", v, 32'h0);
        cyc(1);
        rd(3'd4, v);
        chk("R9 event after three edges", v, 32'h1 << 24);
        chk("R9 irq not yet after three edges", {31'h0, irq_o}, 32'h0);
        cyc(1);
        chk("R9 irq after four edges", {31'h0, irq_o}, 32'h1);
        // R6: clearing another bit leaves this event
        wr(3'd4, 32'h1 << 23);
        rd(3'd4, v);
        chk("R6 unrelated clear keeps event", v, 32'h1 << 24);
        pin_i[7] = 1'b0;
        cyc(5);

        // R8: mode change clears, identical rewrite keeps
        set_mode(5, 0);
        wr(3'd3, 32'h1 << 26);
        wr(3'd4, 32'hFFFF_FFFF);
        cyc(2);
        pin_i[5] = 1'b1;
        cyc(5);
        rd(3'd4, v);
        chk("R8 event before rewrite", v, 32'h1 << 26);
        set_mode(5, 0);
        rd(3'd4, v);
        chk("R8 same code keeps event", v, 32'h1 << 26);
        set_mode(5, 1);
        rd(3'd4, v);
        chk("R8 changed code clears event", v, 32'h0);
        cyc(1);
        chk("R8 irq drops after clear", {31'h0, irq_o}, 32'h0);
        // R8: select-bit change also clears
        wr(3'd4, 32'hFFFF_FFFF);
        pin_i[5] = 1'b0;
        cyc(5);
        set_mode(5, 2);
        wr(3'd4, 32'hFFFF_FFFF);
        pin_i[5] = 1'b1;
        cyc(3);
        pin_i[5] = 1'b0;
        cyc(5);
        rd(3'd4, v);
        chk("R8 falling event pending", v, 32'h1 << 26);
        wr(3'd2, 32'h1 << 26);
        wr(3'd2, 32'h0);
        rd(3'd4, v);
        chk("R8 select change clears event", v, 32'h0);

        // Sweep: all lines, all codes, both select values
        for (int ln = 0; ln < 32; ln++) begin
            for (int m = 0; m < 4; m++) begin
                for (int l = 0; l < 2; l++) begin
                    bit en, rise_ok, fall_ok, lv_hi, lv_lo;
                    string t;
                    t = tag_of(m);
                    en = (ln % 3) != 0;
                    rise_ok = (m == 0) || (m == 1 && l == 0);
                    fall_ok = (m == 0) || (m == 2 && l == 0);
                    lv_hi = (l == 1) && (m == 1);
                    lv_lo = (l == 1) && (m == 2);
                    set_mode(ln, m);
                    wr(3'd2, l ? (32'h1 << (31 - ln)) : 32'h0);
                    wr(3'd3, en ? (32'h1 << (31 - ln)) : 32'h0);
                    cyc(3);
                    wr(3'd4, 32'hFFFF_FFFF);
                    cyc(2);
                    phase_chk({t, " idle low"}, ln, lv_lo, en);
                    pin_i[ln] = 1'b1;
                    cyc(5);
                    phase_chk({t, " after rise"}, ln, lv_hi || rise_ok, en);
                    wr(3'd4, 32'hFFFF_FFFF);
                    cyc(2);
                    phase_chk({t, " R7 after clear"}, ln, lv_hi, en);
                    pin_i[ln] = 1'b0;
                    cyc(5);
                    phase_chk({t, " R7 after fall"}, ln, lv_lo || fall_ok, en);
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule